// File: doc/BRIEF.md
# Ring Node Command Processor

This block is the decision core of one node on a daisy-chained serial ring. A frame arrives already parsed, as a set of parallel fields: command code, target node id, register address, data word, hop count and an answer flag. The node either acts on the frame locally or passes it to the next node.

Acting locally can mean reading or writing a small internal register array, or changing a serial/bridged mode bit. A read produces an answer frame that travels downstream toward the master. Frames that are not meant for this node are passed on. Most of them get their hop count raised by one, so the master can tell how far a frame travelled.

Both edges of the block use a valid/ready handshake. There is one register stage between the input and the output.

Command codes (4 bits): 0x1 read, 0x2 write, 0x3 broadcast read, 0x4 set mode, 0x7 no-operation. Any other code is unknown. Target id 127 means every node. Id 0 is the master and never matches a node. Hop arithmetic is 8-bit and wraps modulo 256.

Top module: `ring_node_cmd`

## Requirements
- R1: After reset, out_valid is 0 and bridge_mode is 0 (serial), and every register entry reads back as 0.
- R2: A read (0x1) with target equal to NODE_ID or 127 is consumed. It produces one answer frame with out_answer=1, out_target=0, out_data equal to the register at the address, and cmd, addr and hop copied from the request.
- R3: A write (0x2) to NODE_ID stores the data at the address and produces no output frame. A write to 127 stores the data and also forwards the frame with hop+1.
- R4: A read, write or set-mode frame whose target is neither NODE_ID nor 127 is forwarded with every field unchanged except hop, which becomes hop+1 modulo 256. It has no local effect.
- R5: A broadcast read (0x3) reads the register at the address whatever the target is. If bit 0 of the read word is 1, it replies as in R2. Otherwise it forwards the frame with all fields unchanged.
- R6: A set-mode command (0x4) addressed to the node loads bridge_mode from data bit 0 (1 = bridged) and ignores the address field. Sent to NODE_ID it is consumed. Sent to 127 it is forwarded with hop+1.
- R7: A no-operation (0x7), or any code not listed, is forwarded with all fields unchanged and has no local effect.
- R8: An incoming frame with answer=1 is forwarded with all fields unchanged, whatever its command and target, and has no local effect.
- R9: in_ready is 1 exactly when the output stage is empty or out_ready is 1. An output frame holds all its fields stable while out_valid=1 and out_ready=0. Frames leave in the order they were accepted, one cycle after acceptance.
- R10: Target id 0 never selects the node, so such a read, write or set-mode frame is forwarded as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming frame present |
| in_ready | output | 1 | Node can take a frame this cycle |
| in_answer | input | 1 | Incoming frame is an answer |
| in_cmd | input | 4 | Command code |
| in_target | input | 7 | Target node id |
| in_hop | input | 8 | Hop count |
| in_addr | input | ADDR_W | Register address |
| in_data | input | DATA_W | Data word |
| out_valid | output | 1 | Outgoing frame present |
| out_ready | input | 1 | Downstream accepts the frame |
| out_answer | output | 1 | Outgoing frame is an answer |
| out_cmd | output | 4 | Command code |
| out_target | output | 7 | Target node id |
| out_hop | output | 8 | Hop count |
| out_addr | output | ADDR_W | Register address |
| out_data | output | DATA_W | Data word |
| bridge_mode | output | 1 | 0 serial, 1 bridged |

## Verification
The bench builds the node with NODE_ID=5, ADDR_W=3 and DATA_W=16. That gives an eight-entry register array, small enough that addresses written through both the own id and the broadcast id can be read back directly. An id of 5 sits apart from 0, 127 and the neighbour ids 6, 8 and 9 that the bench uses for foreign targets. A hop value of 255 on a foreign frame reaches the modulo-256 wrap. A phase with a toggling out_ready holds answers and forwarded frames in the output stage, which tests ordering and field stability under backpressure.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
    localparam int CMD_W = 4;
    localparam int ID_W  = 7;
    localparam int HOP_W = 8;

    localparam logic [CMD_W-1:0] OP_READ   = 4'h1;
    localparam logic [CMD_W-1:0] OP_WRITE  = 4'h2;
    localparam logic [CMD_W-1:0] OP_BREAD  = 4'h3;
    localparam logic [CMD_W-1:0] OP_MODE   = 4'h4;
    localparam logic [CMD_W-1:0] OP_NOP    = 4'h7;

    localparam logic [ID_W-1:0] ID_MASTER = 7'd0;
    localparam logic [ID_W-1:0] ID_ALL    = 7'd127;

    typedef struct packed {
        logic emit;     // a frame leaves the node
        logic reply;    // outgoing frame is an answer built here
        logic hop_inc;  // raise hop count of a passed-on frame
        logic wr_en;    // store data into the register array
        logic mode_en;  // load bridge mode from data bit 0
    } node_act_t;
endpackage

// File: rtl/ring_node_decide.sv
module ring_node_decide
    import ring_node_pkg::*;
#(
    parameter int NODE_ID = 1
) (
    input  logic              frame_answer,
    input  logic [CMD_W-1:0]  frame_cmd,
    input  logic [ID_W-1:0]   frame_target,
    input  logic              rd_bit0,
    output node_act_t         act
);
    localparam logic [ID_W-1:0] SELF_ID = ID_W'(NODE_ID);

    logic is_self;
    logic is_all;
    logic hit;

    always_comb begin
        is_self = (frame_target == SELF_ID) && (frame_target != ID_MASTER);
        is_all  = (frame_target == ID_ALL);
        hit     = is_self || is_all;
        act     = '{emit: 1'b1, reply: 1'b0, hop_inc: 1'b0, wr_en: 1'b0, mode_en: 1'b0};
        if (!frame_answer) begin
            unique case (frame_cmd)
                OP_READ: begin
                    act.reply   = hit;
                    act.hop_inc = !hit;
                end
                OP_WRITE: begin
                    act.wr_en   = hit;
                    act.emit    = !is_self;
                    act.hop_inc = 1'b1;
                end
                OP_BREAD: begin
                    act.reply   = rd_bit0;
                end
                OP_MODE: begin
                    act.mode_en = hit;
                    act.emit    = !is_self;
                    act.hop_inc = 1'b1;
                end
                default: begin
                    // no-operation and unknown codes pass through untouched
                end
            endcase
        end
    end
endmodule

// File: rtl/ring_node_regs.sv
module ring_node_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_comb begin
            mem_d[i] = mem_q[i];
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                mem_d[i] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ring_node_cmd.sv
module ring_node_cmd
    import ring_node_pkg::*;
#(
    parameter int NODE_ID = 1,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_answer,
    input  logic [3:0]        in_cmd,
    input  logic [6:0]        in_target,
    input  logic [7:0]        in_hop,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_answer,
    output logic [3:0]        out_cmd,
    output logic [6:0]        out_target,
    output logic [7:0]        out_hop,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              bridge_mode
);
    typedef struct packed {
        logic              valid;
        logic              answer;
        logic [CMD_W-1:0]  cmd;
        logic [ID_W-1:0]   target;
        logic [HOP_W-1:0]  hop;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              bridge;
    } node_state_t;

    node_state_t st_d, st_q;
    node_act_t   act;
    logic [DATA_W-1:0] rd_data;
    logic              accept;
    logic              wr_en;

    ring_node_decide #(.NODE_ID(NODE_ID)) u_decide (
        .frame_answer (in_answer),
        .frame_cmd    (in_cmd),
        .frame_target (in_target),
        .rd_bit0      (rd_data[0]),
        .act          (act)
    );

    ring_node_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (in_addr),
        .wr_data (in_data),
        .rd_addr (in_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        in_ready = !st_q.valid || out_ready;
        accept   = in_valid && in_ready;
        wr_en    = accept && act.wr_en;
        st_d     = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (accept) begin
            if (act.mode_en) begin
                st_d.bridge = in_data[0];
            end
            if (act.emit) begin
                st_d.valid  = 1'b1;
                st_d.answer = act.reply ? 1'b1 : in_answer;
                st_d.cmd    = in_cmd;
                st_d.target = act.reply ? ID_MASTER : in_target;
                st_d.hop    = act.hop_inc ? in_hop + 8'd1 : in_hop;
                st_d.addr   = in_addr;
                st_d.data   = act.reply ? rd_data : in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_answer  = st_q.answer;
    assign out_cmd     = st_q.cmd;
    assign out_target  = st_q.target;
    assign out_hop     = st_q.hop;
    assign out_addr    = st_q.addr;
    assign out_data    = st_q.data;
    assign bridge_mode = st_q.bridge;

    localparam logic [ID_W-1:0] SELF_ID = ID_W'(NODE_ID);

    // backpressure keeps the pending frame intact
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable({out_answer, out_cmd, out_target, out_hop, out_addr, out_data}));

    // addressed read turns into an answer toward the master
    assert_read_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_answer && in_cmd == OP_READ && (in_target == SELF_ID || in_target == ID_ALL)
        |=> out_valid && out_answer && out_target == ID_MASTER && out_hop == $past(in_hop));

    // foreign read passes on with one more hop
    assert_foreign_hop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_answer && in_cmd == OP_READ && in_target != SELF_ID && in_target != ID_ALL
        |=> out_valid && !out_answer && out_hop == $past(in_hop) + 8'd1 && out_target == $past(in_target));

    // mode bit moves only on an accepted set-mode command
    assert_mode_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bridge_mode) |-> $past(in_valid && in_ready && !in_answer && in_cmd == OP_MODE));

    // answers from upstream are passed on verbatim
    assert_answer_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_answer
        |=> out_valid && out_answer && out_hop == $past(in_hop) && out_data == $past(in_data) && out_target == $past(in_target));

    // no-operation leaves the frame untouched
    assert_nop_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_answer && in_cmd == OP_NOP
        |=> out_valid && out_cmd == OP_NOP && out_hop == $past(in_hop) && out_data == $past(in_data));
endmodule

// File: tb/tb_ring_node_cmd.sv
module tb_ring_node_cmd;
    localparam int NID = 5;
    localparam int AW  = 3;
    localparam int DW  = 16;

    typedef struct packed {
        logic          answer;
        logic [3:0]    cmd;
        logic [6:0]    target;
        logic [7:0]    hop;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } frm_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic in_answer = 1'b0;
    logic [3:0] in_cmd = '0;
    logic [6:0] in_target = '0;
    logic [7:0] in_hop = '0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic out_answer;
    logic [3:0] out_cmd;
    logic [6:0] out_target;
    logic [7:0] out_hop;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;
    logic bridge_mode;

    int total = 0;
    int bad = 0;
    frm_t exp_q[$];
    string tag_q[$];
    logic [DW-1:0] model_regs [1 << AW];
    logic model_bridge = 1'b0;
    bit toggle_ready = 1'b0;
    logic [7:0] rdy_lfsr = 8'hA5;
    bit prev_stall = 1'b0;
    frm_t prev_frm;

    always #2 clk = ~clk;

    ring_node_cmd #(.NODE_ID(NID), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_answer(in_answer),
        .in_cmd(in_cmd), .in_target(in_target), .in_hop(in_hop),
        .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_answer(out_answer),
        .out_cmd(out_cmd), .out_target(out_target), .out_hop(out_hop),
        .out_addr(out_addr), .out_data(out_data), .bridge_mode(bridge_mode)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ready driver: steady high, or pseudo-random while toggling
    always @(posedge clk) begin
        #1;
        if (toggle_ready) begin
            rdy_lfsr = {rdy_lfsr[6:0], rdy_lfsr[7] ^ rdy_lfsr[5] ^ rdy_lfsr[4] ^ rdy_lfsr[3]};
            out_ready = rdy_lfsr[0];
        end else begin
            out_ready = 1'b1;
        end
    end

    // monitor: scoreboard pop plus hold check
    always @(negedge clk) begin
        frm_t got;
        got = '{out_answer, out_cmd, out_target, out_hop, out_addr, out_data};
        if (rst_n) begin
            if (prev_stall) begin
                check("R9 hold", {63'd0, out_valid}, 64'd1);
                check("R9 stable", 64'(got), 64'(prev_frm));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("unexpected frame", 64'(got), 64'd0);
                end else begin
                    check(tag_q.pop_front(), 64'(got), 64'(exp_q.pop_front()));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_frm = got;
        end
    end

    task automatic push(input string tag, input frm_t f);
        exp_q.push_back(f);
        tag_q.push_back(tag);
    endtask

    task automatic send(input string tag, input logic ans, input logic [3:0] cmd,
                        input logic [6:0] tgt, input logic [7:0] hop,
                        input logic [AW-1:0] addr, input logic [DW-1:0] data);
        frm_t f, r, h;
        bit hit;
        f = '{ans, cmd, tgt, hop, addr, data};
        r = '{1'b1, cmd, 7'd0, hop, addr, model_regs[addr]};
        h = f;
        h.hop = hop + 8'd1;
        hit = (tgt == 7'(NID)) || (tgt == 7'd127);
        if (ans) push(tag, f);
        else case (cmd)
            4'h1: push(tag, hit ? r : h);
            4'h2: begin
                if (hit) model_regs[addr] = data;
                if (tgt != 7'(NID)) push(tag, h);
            end
            4'h3: push(tag, model_regs[addr][0] ? r : f);
            4'h4: begin
                if (hit) model_bridge = data[0];
                if (tgt != 7'(NID)) push(tag, h);
            end
            default: push(tag, f);
        endcase
        in_valid = 1'b1; in_answer = ans; in_cmd = cmd; in_target = tgt;
        in_hop = hop; in_addr = addr; in_data = data;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model_regs[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 bridge", {63'd0, bridge_mode}, 64'd0);
        @(posedge clk); #1;
        for (int a = 0; a < (1 << AW); a++) send("R1 reset read", 1'b0, 4'h1, 7'(NID), 8'd2, AW'(a), 16'hFFFF);
        send("R3 own write", 1'b0, 4'h2, 7'(NID), 8'd1, 3'd1, 16'h1235);
        send("R2 own read", 1'b0, 4'h1, 7'(NID), 8'd3, 3'd1, 16'h0000);
        send("R2 all read", 1'b0, 4'h1, 7'd127, 8'd4, 3'd1, 16'h0000);
        send("R3 all write", 1'b0, 4'h2, 7'd127, 8'd6, 3'd2, 16'hA0A0);
        send("R3 readback", 1'b0, 4'h1, 7'(NID), 8'd1, 3'd2, 16'h0000);
        send("R4 foreign write", 1'b0, 4'h2, 7'd6, 8'd9, 3'd3, 16'h7777);
        send("R4 no local write", 1'b0, 4'h1, 7'(NID), 8'd1, 3'd3, 16'h0000);
        send("R4 hop wrap", 1'b0, 4'h1, 7'd9, 8'd255, 3'd1, 16'h0042);
        send("R10 master id", 1'b0, 4'h1, 7'd0, 8'd7, 3'd1, 16'h0011);
        send("R10 master write", 1'b0, 4'h2, 7'd0, 8'd7, 3'd4, 16'h0013);
        send("R5 bread reply", 1'b0, 4'h3, 7'd9, 8'd12, 3'd1, 16'h0000);
        send("R5 bread pass", 1'b0, 4'h3, 7'd9, 8'd12, 3'd2, 16'h5555);
        send("R6 own mode", 1'b0, 4'h4, 7'(NID), 8'd1, 3'd6, 16'h0001);
        drain();
        @(negedge clk);
        check("R6 bridge set", {63'd0, bridge_mode}, 64'd1);
        @(posedge clk); #1;
        send("R6 addr ignored", 1'b0, 4'h1, 7'(NID), 8'd1, 3'd6, 16'h0000);
        send("R4 foreign mode", 1'b0, 4'h4, 7'd8, 8'd3, 3'd0, 16'h0000);
        drain();
        @(negedge clk);
        check("R4 bridge kept", {63'd0, bridge_mode}, 64'd1);
        @(posedge clk); #1;
        send("R6 all mode", 1'b0, 4'h4, 7'd127, 8'd20, 3'd5, 16'hFFFE);
        drain();
        @(negedge clk);
        check("R6 bridge clear", {63'd0, bridge_mode}, {63'd0, model_bridge});
        @(posedge clk); #1;
        send("R7 nop", 1'b0, 4'h7, 7'(NID), 8'd8, 3'd1, 16'hBEEF);
        send("R7 unknown", 1'b0, 4'h9, 7'(NID), 8'd8, 3'd1, 16'hCAFE);
        send("R7 unknown 0", 1'b0, 4'h0, 7'd127, 8'd8, 3'd2, 16'h0001);
        send("R8 answer pass", 1'b1, 4'h2, 7'(NID), 8'd30, 3'd1, 16'h0000);
        send("R8 answer mode", 1'b1, 4'h4, 7'd127, 8'd31, 3'd0, 16'h0000);
        send("R8 no write", 1'b0, 4'h1, 7'(NID), 8'd0, 3'd1, 16'h0000);
        drain();
        @(negedge clk);
        check("R8 bridge kept", {63'd0, bridge_mode}, {63'd0, model_bridge});
        @(posedge clk); #1;
        toggle_ready = 1'b1;
        for (int k = 0; k < 40; k++) begin
            send("R9 order", 1'b0, (k % 3 == 0) ? 4'h1 : 4'h2, (k % 2 == 0) ? 7'(NID) : 7'd127,
                 8'(k), AW'(k), 16'(k * 331));
            send("R9 order fwd", 1'b0, 4'h1, 7'd9, 8'(k), AW'(k + 1), 16'(k));
        end
        toggle_ready = 1'b0;
        drain();
        check("R9 queue empty", 64'(exp_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule